// File: doc/BRIEF.md
# Set-Associative Tag Directory

This block decides, for every address presented to it, whether the line holding that address is already resident. It stores no data. Each set holds one tag and one valid flag per way. A lookup that misses always installs the requested line, so the next access to the same block hits. Each access can carry an uncached/IO flag. A flagged access passes by the block: it is not looked up, does not change the directory and is not counted.

The address has three fields. The least significant bits select a byte inside a block and play no part in the lookup. The bits above them pick the set. Every remaining upper bit is the tag. When a miss lands in a set that still has an empty way, the empty way with the smallest number is filled. When the set is full, a free-running pseudo-random sequence picks the way to replace. A hit changes nothing.

The result of a request shows up on the outputs on the clock edge after it is presented. Two running totals go with it: the accepted accesses and the misses. The default geometry is 8 ways, 32 sets and 64-byte blocks, which is 16 KiB of address space covered.

Top module: `setassoc_tagdir`

## Requirements
- R1: The low log2(BLOCK_BYTES) address bits are ignored. The next log2(SETS) bits select the set, and all bits above those form the tag. Two addresses that differ only in the offset bits give the same result.
- R2: A request accepted at a clock edge produces rsp_valid=1 on that edge. rsp_hit=1 means some valid way of the indexed set holds the request tag. When rsp_valid is 0, rsp_hit is 0.
- R3: Every miss installs the requested line. A request issued in the very next cycle to the same block sees that line and hits.
- R4: After reset, WAYS different tags sent to one set all miss. Afterwards all of them are resident, because each miss filled the lowest empty way and displaced nothing.
- R5: A miss to a set whose ways are all valid displaces exactly one resident line. The way is taken from the low bits of a free-running LFSR, so the displaced line depends on when the miss happens.
- R6: A hit leaves the set contents and the miss count unchanged.
- R7: A request with req_io=1 is ignored: no response, no count change, no allocation and no eviction.
- R8: acc_count increases by exactly one for each accepted (non-IO) request.
- R9: miss_count increases by exactly one for each accepted request that misses, and it never exceeds acc_count.
- R10: A synchronous reset clears every valid flag, both counters and rsp_valid. Requests presented while reset is high are not accepted.
- R11: Sets are independent: filling one set never disturbs lines in another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_io | input | 1 | Request is uncached/IO and must bypass the directory |
| rsp_valid | output | 1 | Registered: the previous cycle held an accepted request |
| rsp_hit | output | 1 | Registered: that request hit |
| acc_count | output | CNT_W | Number of accepted requests since reset |
| miss_count | output | CNT_W | Number of misses since reset |

## Verification
The bench runs a 4-set, 4-way, 16-byte-block configuration. It sweeps every set with fills, then with re-probes at mirrored offsets. Fill order and offset decoding both show up there, because a fill that overwrote a valid way or used the offset in the lookup would turn a re-probe into a miss. IO requests are placed before and after the fills, which shows whether a bypassed access ever allocated or evicted. A miss to a full set is repeated after 0 to 23 idle cycles, and the first original tag that misses on re-probe gives the victim way. That shows exactly one line was displaced and that the choice changes with time.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
  // Default geometry shared by the directory and its checker.
  localparam int unsigned DEF_ADDR_W      = 32;
  localparam int unsigned DEF_WAYS        = 8;
  localparam int unsigned DEF_SETS        = 32;
  localparam int unsigned DEF_BLOCK_BYTES = 64;
  localparam int unsigned DEF_CNT_W       = 32;
  localparam int unsigned DEF_LFSR_W      = 16;
  // Galois feedback mask for x^16 + x^14 + x^13 + x^11 + 1 (maximal length)
  localparam logic [15:0] DEF_LFSR_TAPS   = 16'hB400;
  localparam logic [15:0] DEF_LFSR_SEED   = 16'hACE1;
endpackage

// File: rtl/tagdir_lfsr.sv
module tagdir_lfsr #(
  parameter int unsigned          W     = 16,
  parameter logic [W-1:0]         TAPS  = 16'hB400,
  parameter logic [W-1:0]         SEED  = 16'hACE1,
  parameter int unsigned          OUT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rnd
);
  logic [W-1:0] state_q;

  // Free-running Galois shifter; reseeded to a nonzero value on reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
    end else if (state_q[0]) begin
      state_q <= (state_q >> 1) ^ TAPS;
    end else begin
      state_q <= state_q >> 1;
    end
  end

  assign rnd = state_q[OUT_W-1:0];
endmodule

// File: rtl/tagdir_match.sv
module tagdir_match #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned TAG_W = 21
) (
  input  logic [WAYS*TAG_W-1:0] way_tags,
  input  logic [WAYS-1:0]       way_valid,
  input  logic [TAG_W-1:0]      req_tag,
  output logic                  hit
);
  logic [WAYS-1:0] eq;

  // One comparator per way, qualified by that way's valid flag.
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == req_tag);
  end

  assign hit = |eq;
endmodule

// File: rtl/tagdir_victim.sv
module tagdir_victim #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned WAY_W = 3
) (
  input  logic [WAYS-1:0]  way_valid,
  input  logic [WAY_W-1:0] rnd,
  output logic [WAY_W-1:0] victim
);
  // Lowest-numbered empty way wins; a full set falls back to the random pick.
  always_comb begin
    victim = rnd;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!way_valid[i]) begin
        victim = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/setassoc_tagdir.sv
module setassoc_tagdir #(
  parameter int unsigned ADDR_W      = tagdir_pkg::DEF_ADDR_W,
  parameter int unsigned WAYS        = tagdir_pkg::DEF_WAYS,
  parameter int unsigned SETS        = tagdir_pkg::DEF_SETS,
  parameter int unsigned BLOCK_BYTES = tagdir_pkg::DEF_BLOCK_BYTES,
  parameter int unsigned CNT_W       = tagdir_pkg::DEF_CNT_W,
  parameter int unsigned LFSR_W      = tagdir_pkg::DEF_LFSR_W,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = tagdir_pkg::DEF_LFSR_TAPS,
  parameter logic [LFSR_W-1:0] LFSR_SEED = tagdir_pkg::DEF_LFSR_SEED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_io,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [CNT_W-1:0]  acc_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int unsigned OFF_W = $clog2(BLOCK_BYTES);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned WAY_W = $clog2(WAYS);
  localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W;

  // Address split: offset bits are dropped, tag is kept compact.
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  assign idx = req_addr[OFF_W +: IDX_W];
  assign tag = req_addr[ADDR_W-1 -: TAG_W];

  logic accept;
  assign accept = req_valid && !req_io && !rst;

  // Valid flags live in flops so reset can clear them in one cycle.
  logic [WAYS-1:0] valid_q [SETS];
  logic [WAYS-1:0] set_valid;
  assign set_valid = valid_q[idx];

  logic [WAYS*TAG_W-1:0] set_tags;
  logic                  hit;
  logic [WAY_W-1:0]      rnd_way;
  logic [WAY_W-1:0]      victim;
  logic                  fill;
  assign fill = accept && !hit;

  // One tag memory per way: single write port, asynchronous read.
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    always_ff @(posedge clk) begin
      if (fill && (victim == WAY_W'(w))) begin
        tag_mem[idx] <= tag;
      end
    end
    assign set_tags[w*TAG_W +: TAG_W] = tag_mem[idx];
  end

  tagdir_match #(.WAYS(WAYS), .TAG_W(TAG_W)) match_i (
    .way_tags  (set_tags),
    .way_valid (set_valid),
    .req_tag   (tag),
    .hit       (hit)
  );

  tagdir_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED), .OUT_W(WAY_W)) lfsr_i (
    .clk (clk),
    .rst (rst),
    .rnd (rnd_way)
  );

  tagdir_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) victim_i (
    .way_valid (set_valid),
    .rnd       (rnd_way),
    .victim    (victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
      end
    end else if (fill) begin
      valid_q[idx][victim] <= 1'b1;
    end
  end

  // Registered response and running totals.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      acc_count  <= '0;
      miss_count <= '0;
    end else begin
      rsp_valid <= accept;
      rsp_hit   <= accept && hit;
      if (accept) begin
        acc_count <= acc_count + CNT_W'(1);
      end
      if (fill) begin
        miss_count <= miss_count + CNT_W'(1);
      end
    end
  end
endmodule

module setassoc_tagdir_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_io,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [CNT_W-1:0] acc_count,
  input logic [CNT_W-1:0] miss_count
);
  a_r2_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !rsp_hit);

  a_r2_accept_responds: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_io) |=> rsp_valid);

  a_r7_io_ignored: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_io) |=> (!rsp_valid && $stable(acc_count) && $stable(miss_count)));

  a_r8_acc_step: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ((acc_count - $past(acc_count)) == CNT_W'(1)));

  a_r9_miss_step: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> ((miss_count - $past(miss_count)) == CNT_W'(1)));

  a_r6_hit_keeps_miss: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> $stable(miss_count));

  a_r9_miss_bounded: assert property (@(posedge clk) disable iff (rst)
    miss_count <= acc_count);
endmodule

bind setassoc_tagdir setassoc_tagdir_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_io     (req_io),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .acc_count  (acc_count),
  .miss_count (miss_count)
);

// File: tb/setassoc_tagdir_tb_top.sv
module setassoc_tagdir_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 16;
  localparam int NW   = 4;
  localparam int NS   = 4;
  localparam int BB   = 16;
  localparam int CW   = 16;
  localparam int OFFW = 4;
  localparam int IDXW = 2;
  localparam int TAGW = AW - OFFW - IDXW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_io = 1'b0;
  logic          rsp_valid;
  logic          rsp_hit;
  logic [CW-1:0] acc_count;
  logic [CW-1:0] miss_count;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_acc  = 0;
  int exp_miss = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  setassoc_tagdir #(
    .ADDR_W(AW), .WAYS(NW), .SETS(NS), .BLOCK_BYTES(BB), .CNT_W(CW)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_io(req_io), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .acc_count(acc_count), .miss_count(miss_count)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic [AW-1:0] mk(int t, int s, int o);
    return {TAGW'(t), IDXW'(s), OFFW'(o)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_counts(string req);
    chk(acc_count == CW'(exp_acc), req, int'(acc_count), exp_acc);
    chk(miss_count == CW'(exp_miss), req, int'(miss_count), exp_miss);
  endtask

  // Starts and ends at a negedge; the result is sampled one edge later.
  task automatic access(int t, int s, int o, bit io, output bit hit, output bit rv);
    req_valid = 1'b1;
    req_addr  = mk(t, s, o);
    req_io    = io;
    @(negedge clk);
    hit = rsp_hit;
    rv  = rsp_valid;
    req_valid = 1'b0;
    req_io    = 1'b0;
    if (!io) begin
      exp_acc++;
      if (!hit) exp_miss++;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    exp_acc = 0;
    exp_miss = 0;
  endtask

  initial begin
    bit h, v;
    bit [NW-1:0] seen;
    int victim;

    // R10: requests held during reset are not accepted
    req_valid = 1'b1;
    req_addr  = mk(5, 0, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 rsp_valid after reset", int'(rsp_valid), 0);
    chk_counts("R10 counters after reset");

    // R7: IO requests before any fill
    for (int s = 0; s < NS; s++) begin
      access(100 + s, s, 0, 1'b1, h, v);
      chk(v == 1'b0, "R7 io gives no response", int'(v), 0);
      chk_counts("R7 io not counted");
    end

    // R2, R8, R9, R10: fills of every set after reset all miss
    for (int s = 0; s < NS; s++) begin
      for (int w = 0; w < NW; w++) begin
        access(w + 1, s, w, 1'b0, h, v);
        chk(v == 1'b1, "R2 response valid", int'(v), 1);
        chk(h == 1'b0, "R2 R10 first touch misses", int'(h), 0);
        chk_counts("R8 R9 counts on fill");
      end
    end

    // R1, R4, R6, R11: everything resident, probed at mirrored offsets
    for (int s = 0; s < NS; s++) begin
      for (int w = 0; w < NW; w++) begin
        access(w + 1, s, BB - 1 - w, 1'b0, h, v);
        chk(h == 1'b1, "R1 R4 R11 resident line hits", int'(h), 1);
        chk_counts("R6 R8 hit counts");
      end
    end

    // R7: IO to a full set must not evict
    for (int s = 0; s < NS; s++) begin
      access(200, s, 0, 1'b1, h, v);
      chk(v == 1'b0, "R7 io on full set no response", int'(v), 0);
    end
    chk_counts("R7 io on full set not counted");
    for (int s = 0; s < NS; s++) begin
      for (int w = 0; w < NW; w++) begin
        access(w + 1, s, 3, 1'b0, h, v);
        chk(h == 1'b1, "R7 R6 lines survive io", int'(h), 1);
      end
    end

    // R3: back-to-back miss then hit on the same block
    do_reset();
    access(7, 2, 1, 1'b0, h, v);
    chk(h == 1'b0, "R3 first access misses", int'(h), 0);
    access(7, 2, 9, 1'b0, h, v);
    chk(h == 1'b1, "R3 next-cycle access hits", int'(h), 1);
    chk_counts("R3 R8 R9 counts");

    // R5: miss into a full set at different times
    seen = '0;
    for (int k = 0; k < 24; k++) begin
      do_reset();
      for (int w = 0; w < NW; w++) access(w + 1, 1, 0, 1'b0, h, v);
      repeat (k) @(negedge clk);
      access(9, 1, 0, 1'b0, h, v);
      chk(h == 1'b0, "R5 new tag into full set misses", int'(h), 0);
      access(9, 1, 5, 1'b0, h, v);
      chk(h == 1'b1, "R3 R5 new tag now resident", int'(h), 1);
      victim = -1;
      for (int w = 0; w < NW; w++) begin
        if (victim < 0) begin
          access(w + 1, 1, 0, 1'b0, h, v);
          if (!h) victim = w;
        end
      end
      chk(victim >= 0, "R5 exactly one original line displaced", victim, 0);
      if (victim >= 0) seen[victim] = 1'b1;
      chk_counts("R5 R9 counts after eviction");
    end
    chk($countones(seen) >= 2, "R5 victim way varies", $countones(seen), 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule